// File: doc/BRIEF.md
# Width-Selectable Word Serializer with Squelch and Line Bypass

This block converts parallel words into a single-bit stream. It runs entirely in the fast serial clock domain and sends one bit per cycle. It produces its own word-rate load strobe, and an upstream source presents the next word while that strobe is high. A width-mode input chooses whether each word carries 16 bits or 4 bits. A bit-order input chooses whether the stream starts at the lowest-index bit or at the highest-index bit of the word. The block samples both inputs only when it captures a word, so a word is never cut short and its order never changes partway through.

Two overrides sit at the output. An active-low squelch holds the stream at zero, which keeps corrupted data out of the line. An active-low line-loopback control sends a recovered receive bit straight to the output in place of the serialized data. While loopback is active, squelch has no effect.

Top module: `wser_top`

## Requirements
- R1: After reset, `loadStrobe` is high in the first cycle. `serOut` stays 0 until the first captured word starts to shift out.
- R2: In 16-bit mode (`wideMode`=1 at capture), `loadStrobe` is high for one cycle in every 16. The word on `wordIn` is captured at the clock edge that ends each strobe cycle.
- R3: In 4-bit mode (`wideMode`=0 at capture), `loadStrobe` is high for one cycle in every 4.
- R4: With `msbFirst`=0, bit k of the captured word appears on `serOut` in the k-th cycle after the strobe, counting from 0. So bit 0 goes first, and the last bit is 15 in 16-bit mode or 3 in 4-bit mode.
- R5: With `msbFirst`=1, the top bit goes first (15 in 16-bit mode, 3 in 4-bit mode), and the rest follow in descending order down to bit 0.
- R6: In 4-bit mode only `wordIn[3:0]` is sent. Bits 15:4 have no effect on `serOut`.
- R7: A change of `wideMode` between strobes has no effect on the word in flight. Its length and its strobe spacing follow the value sampled at capture.
- R8: When `squelchN`=0 and `loopN`=1, `serOut` is 0. Strobe timing is unaffected.
- R9: When `loopN`=0, `serOut` equals `rxBit` in the same cycle, whatever the value of `squelchN`.
- R10: A change of `msbFirst` or `wordIn` between strobes has no effect on the bits of the word in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wordIn | input | 16 | Parallel word, sampled at the edge ending a strobe cycle |
| wideMode | input | 1 | 1: 16-bit words, 0: 4-bit words |
| msbFirst | input | 1 | 1: highest-index bit first, 0: bit 0 first |
| squelchN | input | 1 | Active-low squelch that forces the output to zero |
| loopN | input | 1 | Active-low line loopback that passes `rxBit` to the output |
| rxBit | input | 1 | Recovered receive bit used in loopback |
| serOut | output | 1 | Serial data output |
| loadStrobe | output | 1 | Word-rate strobe, high in the cycle before a word's first bit |

## Verification
The bench builds the block with its default widths of 16 and 4. At these widths it can sweep every 4-bit word value in both bit orders, and it sends a set of 16-bit patterns in both orders. The patterns include single-bit words, which make any misplaced bit visible. Some words carry nonzero upper bits while in 4-bit mode, and in some words the mode, order and word inputs are flipped partway through. The bench also runs squelched words and a loopback stretch in which `squelchN` is held low.

// File: rtl/wser_pkg.sv
package wser_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic load;   // capture wordIn this cycle
    logic wide;   // width sampled at capture
    logic msb;    // order sampled at capture
  } ctlStrobe_t;
endpackage

// File: rtl/wser_ctrl.sv
module wser_ctrl
  import wser_pkg::*;
#(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wideMode,
  input  logic       msbFirst,
  output ctlStrobe_t ctl,
  output logic       loadStrobe
);
  localparam int CW = $clog2(WIDE_W);

  logic [CW-1:0] bitCnt;
  logic          atBoundary;

  assign atBoundary = (bitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (atBoundary) begin
      bitCnt <= wideMode ? CW'(WIDE_W - 1) : CW'(NARROW_W - 1);
    end else begin
      bitCnt <= bitCnt - 1'b1;
    end
  end

  always_comb begin
    ctl.load   = atBoundary;
    ctl.wide   = wideMode;
    ctl.msb    = msbFirst;
    loadStrobe = atBoundary;
  end
endmodule

// File: rtl/wser_dpath.sv
module wser_dpath
  import wser_pkg::*;
#(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIDE_W-1:0] wordIn,
  input  ctlStrobe_t        ctl,
  input  logic              squelchN,
  input  logic              loopN,
  input  logic              rxBit,
  output logic              serOut
);
  localparam int PAD_W = WIDE_W - NARROW_W;

  logic [WIDE_W-1:0]   shiftReg;
  logic [WIDE_W-1:0]   revWide;
  logic [NARROW_W-1:0] revNarrow;
  logic [WIDE_W-1:0]   loadVal;

  for (genvar i = 0; i < WIDE_W; i++) begin : g_revWide
    assign revWide[i] = wordIn[WIDE_W-1-i];
  end
  for (genvar i = 0; i < NARROW_W; i++) begin : g_revNarrow
    assign revNarrow[i] = wordIn[NARROW_W-1-i];
  end

  // Order is fixed at capture: the first bit to send lands in position 0
  always_comb begin
    unique case ({ctl.wide, ctl.msb})
      2'b11:   loadVal = revWide;
      2'b10:   loadVal = wordIn;
      2'b01:   loadVal = {{PAD_W{1'b0}}, revNarrow};
      default: loadVal = {{PAD_W{1'b0}}, wordIn[NARROW_W-1:0]};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (ctl.load) begin
      shiftReg <= loadVal;
    end else begin
      shiftReg <= {1'b0, shiftReg[WIDE_W-1:1]};
    end
  end

  always_comb begin
    if (!loopN)         serOut = rxBit;
    else if (!squelchN) serOut = 1'b0;
    else                serOut = shiftReg[0];
  end
endmodule

// File: rtl/wser_top.sv
module wser_top
  import wser_pkg::*;
#(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIDE_W-1:0] wordIn,
  input  logic              wideMode,
  input  logic              msbFirst,
  input  logic              squelchN,
  input  logic              loopN,
  input  logic              rxBit,
  output logic              serOut,
  output logic              loadStrobe
);
  ctlStrobe_t ctl;

  wser_ctrl #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wideMode(wideMode), .msbFirst(msbFirst),
    .ctl(ctl), .loadStrobe(loadStrobe)
  );

  wser_dpath #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_dpath (
    .clk(clk), .rstN(rstN), .wordIn(wordIn), .ctl(ctl),
    .squelchN(squelchN), .loopN(loopN), .rxBit(rxBit), .serOut(serOut)
  );
endmodule

// File: rtl/wser_chk.sv
module wser_chk #(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 4
) (
  input logic clk,
  input logic rstN,
  input logic wideMode,
  input logic squelchN,
  input logic loopN,
  input logic rxBit,
  input logic serOut,
  input logic loadStrobe
);
  localparam int GW = $clog2(WIDE_W) + 2;

  logic [GW-1:0] gap;
  logic          seen;
  logic          curWide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gap <= '0; seen <= 1'b0; curWide <= 1'b0;
    end else if (loadStrobe) begin
      gap <= GW'(1); seen <= 1'b1; curWide <= wideMode;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  p_wide_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (seen && curWide && loadStrobe) |-> (gap == GW'(WIDE_W)));
  p_narrow_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (seen && !curWide && loadStrobe) |-> (gap == GW'(NARROW_W)));
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!seen && loopN) |-> !serOut);
  p_squelch_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (loopN && !squelchN) |-> !serOut);
  p_loop_pass_r9: assert property (@(posedge clk) disable iff (!rstN)
    !loopN |-> (serOut == rxBit));
endmodule

bind wser_top wser_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (
  .clk(clk), .rstN(rstN), .wideMode(wideMode), .squelchN(squelchN),
  .loopN(loopN), .rxBit(rxBit), .serOut(serOut), .loadStrobe(loadStrobe)
);

// File: tb/wser_top_tb.sv
module wser_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] wordIn = '0;
  logic        wideMode = 1'b1, msbFirst = 1'b0, squelchN = 1'b1;
  logic        loopN = 1'b1, rxBit = 1'b0;
  logic        serOut, loadStrobe;
  int          nChk = 0, nFail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wser_top u_dut (
    .clk(clk), .rstN(rstN), .wordIn(wordIn), .wideMode(wideMode),
    .msbFirst(msbFirst), .squelchN(squelchN), .loopN(loopN), .rxBit(rxBit),
    .serOut(serOut), .loadStrobe(loadStrobe)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge where the strobe is expected high
  task automatic sendWord(input logic [15:0] w, input logic wide, input logic msb,
                          input logic sq, input logic flip);
    int len = wide ? 16 : 4;
    string strTag = wide ? "R2" : "R3";
    string bitTag;
    chk(strTag, loadStrobe, 1'b1);
    wordIn = w; wideMode = wide; msbFirst = msb; squelchN = ~sq;
    if (sq) bitTag = "R8";
    else if (flip) bitTag = "R7_R10";
    else if (!wide) bitTag = msb ? "R5_R6" : "R4_R6";
    else bitTag = msb ? "R5" : "R4";
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      chk(bitTag, serOut, sq ? 1'b0 : (msb ? w[len-1-k] : w[k]));
      chk(flip ? "R7" : strTag, loadStrobe, (k == len-1));
      if (flip && k == 0) begin
        wideMode = ~wide; msbFirst = ~msb; wordIn = ~w;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", loadStrobe, 1'b1);
    chk("R1", serOut, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", loadStrobe, 1'b0);
    chk("R1", serOut, 1'b0);
    // resync: wait for strobe
    while (!loadStrobe) @(negedge clk);
    for (int wd = 1; wd >= 0; wd--)
      for (int m = 0; m < 2; m++) begin
        sendWord(16'h0001, wd[0], m[0], 1'b0, 1'b0);
        sendWord(16'h8000, wd[0], m[0], 1'b0, 1'b0);
        sendWord(16'hA5C3, wd[0], m[0], 1'b0, 1'b0);
        sendWord(16'h1234, wd[0], m[0], 1'b0, 1'b0);
        sendWord(16'h6B2E, wd[0], m[0], 1'b0, 1'b1);
      end
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 16; v++)
        sendWord({12'hF3A, v[3:0]}, 1'b0, m[0], 1'b0, 1'b0);
    sendWord(16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0);
    sendWord(16'hFFFF, 1'b0, 1'b1, 1'b1, 1'b0);
    sendWord(16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b0);
    // line loopback with squelch active
    loopN = 1'b0; squelchN = 1'b0;
    for (int k = 0; k < 24; k++) begin
      rxBit = ((k * 5) % 3) == 1;
      @(negedge clk);
      chk("R9", serOut, ((k * 5) % 3) == 1);
    end
    loopN = 1'b1; squelchN = 1'b1;
    while (!loadStrobe) @(negedge clk);
    sendWord(16'h4C71, 1'b1, 1'b0, 1'b0, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end
endmodule